// File: doc/BRIEF.md
# Vector Operand Source Selector

This block sits beside the issue logic of a vectorized loop body. Every source or destination operand of the body owns a slot, which is loaded when the body is dispatched. The slot records whether the register is live on entry to the body and whether it is live on exit. It also records the vector queue assigned to the operand and the global physical register assigned to it. When the issue logic sends out one instance (iteration) of an operand, the block says whether that instance reads the global register or an element of the queue, and gives the register number or the queue number and element address.

Producer writes pass through the block as well. It turns the iteration number into a queue element address. It holds the write back while the target element still carries a value that nobody has read. Once the issue controller has reported the final iteration of a slot, the block recognises the write of that iteration for a live-out register and sends it to the global register as well as to the queue. The block keeps one busy bit per global register. The bit is raised when a live-out register is dispatched and dropped when its final value reaches the global register.

Top module: `vq_src_select`

## Requirements
- R1: After reset all busy bits are 0 and all slots are empty, so an issue to any slot gives `rd_valid` = 0 and a write gives `wr_q_en` = 0.
- R2: An instance issued on a slot that has its live-on-entry flag set reads the global register: `rd_from_q` = 0 and `rd_preg` equals the slot's register number.
- R3: A slot loaded with both live-on-entry and live-on-exit set (a recurrence) reads the global register on its first issued instance. Every later instance reads the queue (`rd_from_q` = 1) whose number was loaded into the slot.
- R4: A slot loaded with live-on-entry set and live-on-exit clear always reads the global register, and producer writes addressed to it are dropped (`wr_q_en` = 0, `wr_g_en` = 0, `wr_stall` = 0).
- R5: A slot with live-on-entry clear reads its queue. The element address `rd_qaddr` is the iteration number modulo QDEPTH (QDEPTH is a power of two, default 8).
- R6: Dispatching a slot with live-on-exit set raises the busy bit of its global register in the next cycle. Dispatching a slot with live-on-exit clear leaves every busy bit unchanged.
- R7: An accepted write on a live-out slot whose iteration equals the final iteration reported for that slot gives `wr_g_en` = 1, and the busy bit of `wr_preg` reads 0 in the next cycle.
- R8: A write of any other iteration, a write on a slot that is not live-out, or a write before a final iteration has been reported gives `wr_g_en` = 0 and changes no busy bit.
- R9: A write to a queue element that was written earlier and has not been read since gives `wr_stall` = 1 and `wr_q_en` = 0. A queue read of that element frees it for the next write.
- R10: Dispatching a slot that has a queue mapping (any slot except the one in R4) marks every element of that queue as free.
- R11: An accepted write reports the slot's queue as `wr_qid`, the iteration number modulo QDEPTH as `wr_qaddr`, and the slot's global register as `wr_preg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Load a slot this cycle |
| disp_slot | input | SL_W | Slot to load |
| disp_lie | input | 1 | Register is live on entry |
| disp_lix | input | 1 | Register is live on exit |
| disp_qid | input | QID_W | Queue assigned to the operand |
| disp_preg | input | PR_W | Global register assigned to the operand |
| vl_valid | input | 1 | Final iteration known for a slot |
| vl_slot | input | SL_W | Slot the final iteration belongs to |
| vl_last | input | ITER_W | Final iteration number |
| iss_valid | input | 1 | An instance is issued |
| iss_slot | input | SL_W | Slot of the issued instance |
| iss_iter | input | ITER_W | Iteration number of the instance |
| rd_valid | output | 1 | Issue hit a loaded slot |
| rd_from_q | output | 1 | 1 = read queue, 0 = read global register |
| rd_preg | output | PR_W | Global register to read |
| rd_qid | output | QID_W | Queue to read |
| rd_qaddr | output | QA_W | Queue element to read |
| wr_valid | input | 1 | Producer write request |
| wr_slot | input | SL_W | Slot of the producer |
| wr_iter | input | ITER_W | Iteration of the produced value |
| wr_q_en | output | 1 | Write accepted into the queue |
| wr_g_en | output | 1 | Write also goes to the global register |
| wr_stall | output | 1 | Target element still holds unread data |
| wr_qid | output | QID_W | Queue written |
| wr_qaddr | output | QA_W | Queue element written |
| wr_preg | output | PR_W | Global register written |
| busy_o | output | NPREG | Busy bit per global register |

## Verification
On every cycle the assertions check how the busy bits follow dispatches and final writes, that a stalled write never enters a queue, that a global write is always also a queue write, and that reset leaves no register busy. The switch of a recurrence operand from global register to queue, the address wrap at the queue depth, the freeing of an element by a read, the emptying of a queue by a new dispatch, and the fact that non-final iterations are not committed can only be shown by the bench's scenarios. The bench compares these against its own model on every cycle.

// File: rtl/vq_src_select.sv
module vq_src_select #(
  parameter int SLOTS  = 8,
  parameter int NQ     = 8,
  parameter int QDEPTH = 8,
  parameter int NPREG  = 32,
  parameter int ITER_W = 8,
  localparam int SL_W  = $clog2(SLOTS),
  localparam int QID_W = $clog2(NQ),
  localparam int QA_W  = $clog2(QDEPTH),
  localparam int PR_W  = $clog2(NPREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [SL_W-1:0]   disp_slot,
  input  logic              disp_lie,
  input  logic              disp_lix,
  input  logic [QID_W-1:0]  disp_qid,
  input  logic [PR_W-1:0]   disp_preg,
  input  logic              vl_valid,
  input  logic [SL_W-1:0]   vl_slot,
  input  logic [ITER_W-1:0] vl_last,
  input  logic              iss_valid,
  input  logic [SL_W-1:0]   iss_slot,
  input  logic [ITER_W-1:0] iss_iter,
  output logic              rd_valid,
  output logic              rd_from_q,
  output logic [PR_W-1:0]   rd_preg,
  output logic [QID_W-1:0]  rd_qid,
  output logic [QA_W-1:0]   rd_qaddr,
  input  logic              wr_valid,
  input  logic [SL_W-1:0]   wr_slot,
  input  logic [ITER_W-1:0] wr_iter,
  output logic              wr_q_en,
  output logic              wr_g_en,
  output logic              wr_stall,
  output logic [QID_W-1:0]  wr_qid,
  output logic [QA_W-1:0]   wr_qaddr,
  output logic [PR_W-1:0]   wr_preg,
  output logic [NPREG-1:0]  busy_o
);

  logic [SLOTS-1:0]  s_val, s_lie, s_lix, s_known;
  logic [QID_W-1:0]  s_qid  [SLOTS];
  logic [PR_W-1:0]   s_preg [SLOTS];
  logic [ITER_W-1:0] s_last [SLOTS];
  logic [QDEPTH-1:0] occ    [NQ];
  logic [NPREG-1:0]  busy;

  logic wr_ok, disp_has_q;

  assign rd_valid  = iss_valid & s_val[iss_slot];
  assign rd_from_q = rd_valid & ~s_lie[iss_slot];
  assign rd_preg   = s_preg[iss_slot];
  assign rd_qid    = s_qid[iss_slot];
  assign rd_qaddr  = iss_iter[QA_W-1:0];

  assign wr_qid    = s_qid[wr_slot];
  assign wr_qaddr  = wr_iter[QA_W-1:0];
  assign wr_preg   = s_preg[wr_slot];
  assign wr_ok     = wr_valid & s_val[wr_slot] & ~(s_lie[wr_slot] & ~s_lix[wr_slot]);
  assign wr_stall  = wr_ok & occ[wr_qid][wr_qaddr];
  assign wr_q_en   = wr_ok & ~wr_stall;
  assign wr_g_en   = wr_q_en & s_lix[wr_slot] & s_known[wr_slot] &
                     (wr_iter == s_last[wr_slot]);

  assign disp_has_q = ~(disp_lie & ~disp_lix);
  assign busy_o     = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_val   <= '0;
      s_lie   <= '0;
      s_lix   <= '0;
      s_known <= '0;
      busy    <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        s_qid[i]  <= '0;
        s_preg[i] <= '0;
        s_last[i] <= '0;
      end
      for (int q = 0; q < NQ; q++) occ[q] <= '0;
    end else begin
      if (rd_valid && s_lie[iss_slot] && s_lix[iss_slot])
        s_lie[iss_slot] <= 1'b0;
      if (vl_valid) begin
        s_known[vl_slot] <= 1'b1;
        s_last[vl_slot]  <= vl_last;
      end
      if (disp_valid) begin
        s_val[disp_slot]   <= 1'b1;
        s_lie[disp_slot]   <= disp_lie;
        s_lix[disp_slot]   <= disp_lix;
        s_known[disp_slot] <= 1'b0;
        s_qid[disp_slot]   <= disp_qid;
        s_preg[disp_slot]  <= disp_preg;
      end

      for (int q = 0; q < NQ; q++) begin
        for (int e = 0; e < QDEPTH; e++) begin
          if (wr_q_en && wr_qid == QID_W'(q) && wr_qaddr == QA_W'(e))
            occ[q][e] <= 1'b1;
          else if (disp_valid && disp_has_q && disp_qid == QID_W'(q))
            occ[q][e] <= 1'b0;
          else if (rd_from_q && rd_qid == QID_W'(q) && rd_qaddr == QA_W'(e))
            occ[q][e] <= 1'b0;
        end
      end

      for (int p = 0; p < NPREG; p++) begin
        if (disp_valid && disp_lix && disp_preg == PR_W'(p))
          busy[p] <= 1'b1;
        else if (wr_g_en && wr_preg == PR_W'(p))
          busy[p] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vq_src_select_chk.sv
module vq_src_select_chk #(
  parameter int NPREG = 32,
  parameter int PR_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_lix,
  input logic [PR_W-1:0]  disp_preg,
  input logic             wr_valid,
  input logic             wr_q_en,
  input logic             wr_g_en,
  input logic             wr_stall,
  input logic [PR_W-1:0]  wr_preg,
  input logic [NPREG-1:0] busy_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> busy_o == '0);

  assert_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_lix |=> busy_o[$past(disp_preg)]);

  assert_busy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_g_en && !(disp_valid && disp_lix && disp_preg == wr_preg)
    |=> !busy_o[$past(wr_preg)]);

  assert_global_only_with_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_g_en |-> wr_valid && wr_q_en);

  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> wr_valid && !wr_q_en && !wr_g_en);

endmodule

bind vq_src_select vq_src_select_chk #(.NPREG(NPREG), .PR_W(PR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_lix(disp_lix),
  .disp_preg(disp_preg), .wr_valid(wr_valid), .wr_q_en(wr_q_en),
  .wr_g_en(wr_g_en), .wr_stall(wr_stall), .wr_preg(wr_preg), .busy_o(busy_o)
);

// File: tb/test_vq_src_select.sv
module test_vq_src_select;
  localparam int SLOTS = 8, NQ = 8, QDEPTH = 8, NPREG = 32, ITER_W = 8;
  localparam int SL_W = 3, QID_W = 3, QA_W = 3, PR_W = 5;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic disp_valid, disp_lie, disp_lix, vl_valid, iss_valid, wr_valid;
  logic [SL_W-1:0] disp_slot, vl_slot, iss_slot, wr_slot;
  logic [QID_W-1:0] disp_qid;
  logic [PR_W-1:0] disp_preg;
  logic [ITER_W-1:0] vl_last, iss_iter, wr_iter;
  logic rd_valid, rd_from_q, wr_q_en, wr_g_en, wr_stall;
  logic [PR_W-1:0] rd_preg, wr_preg;
  logic [QID_W-1:0] rd_qid, wr_qid;
  logic [QA_W-1:0] rd_qaddr, wr_qaddr;
  logic [NPREG-1:0] busy_o;

  vq_src_select i_vq_src_select (.*);

  int tests = 0, fails = 0;

  bit m_val[SLOTS], m_lie[SLOTS], m_lix[SLOTS], m_known[SLOTS];
  int m_qid[SLOTS], m_preg[SLOTS], m_last[SLOTS];
  bit m_occ[NQ][QDEPTH];
  bit m_busy[NPREG];

  localparam int VW = 1 + 1 + PR_W + QID_W + QA_W + 1 + 1 + 1 + QID_W + QA_W + PR_W + NPREG;

  function automatic logic [VW-1:0] model_out();
    bit rv, rq, ok, st, qe, ge;
    logic [NPREG-1:0] b;
    int wq;
    rv = iss_valid && m_val[iss_slot];
    rq = rv && !m_lie[iss_slot];
    wq = m_qid[wr_slot];
    ok = wr_valid && m_val[wr_slot] && !(m_lie[wr_slot] && !m_lix[wr_slot]);
    st = ok && m_occ[wq][wr_iter % QDEPTH];
    qe = ok && !st;
    ge = qe && m_lix[wr_slot] && m_known[wr_slot] && (int'(wr_iter) == m_last[wr_slot]);
    for (int p = 0; p < NPREG; p++) b[p] = m_busy[p];
    return {rv, rq, PR_W'(m_preg[iss_slot]), QID_W'(m_qid[iss_slot]),
            QA_W'(iss_iter % QDEPTH), qe, ge, st, QID_W'(wq),
            QA_W'(wr_iter % QDEPTH), PR_W'(m_preg[wr_slot]), b};
  endfunction

  function automatic logic [VW-1:0] dut_out();
    return {rd_valid, rd_from_q, rd_preg, rd_qid, rd_qaddr, wr_q_en, wr_g_en,
            wr_stall, wr_qid, wr_qaddr, wr_preg, busy_o};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) begin
      m_val[i] = 0; m_lie[i] = 0; m_lix[i] = 0; m_known[i] = 0;
      m_qid[i] = 0; m_preg[i] = 0; m_last[i] = 0;
    end
    for (int q = 0; q < NQ; q++) for (int e = 0; e < QDEPTH; e++) m_occ[q][e] = 0;
    for (int p = 0; p < NPREG; p++) m_busy[p] = 0;
  endtask

  task automatic model_step();
    logic [VW-1:0] o;
    bit rq, qe, ge;
    int wq, rqid, ri, wi;
    o = model_out();
    rq = o[VW-2];
    qe = o[NPREG + PR_W + QA_W + QID_W + 2];
    ge = o[NPREG + PR_W + QA_W + QID_W + 1];
    wq = m_qid[wr_slot]; wi = wr_iter % QDEPTH;
    rqid = m_qid[iss_slot]; ri = iss_iter % QDEPTH;
    if (rq) m_occ[rqid][ri] = 0;
    if (disp_valid && !(disp_lie && !disp_lix))
      for (int e = 0; e < QDEPTH; e++) m_occ[disp_qid][e] = 0;
    if (qe) m_occ[wq][wi] = 1;
    if (ge) m_busy[m_preg[wr_slot]] = 0;
    if (disp_valid && disp_lix) m_busy[disp_preg] = 1;
    if (iss_valid && m_val[iss_slot] && m_lie[iss_slot] && m_lix[iss_slot])
      m_lie[iss_slot] = 0;
    if (vl_valid) begin m_known[vl_slot] = 1; m_last[vl_slot] = vl_last; end
    if (disp_valid) begin
      m_val[disp_slot] = 1; m_lie[disp_slot] = disp_lie; m_lix[disp_slot] = disp_lix;
      m_known[disp_slot] = 0; m_qid[disp_slot] = disp_qid; m_preg[disp_slot] = disp_preg;
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_slot = 0; disp_lie = 0; disp_lix = 0; disp_qid = 0; disp_preg = 0;
    vl_valid = 0; vl_slot = 0; vl_last = 0;
    iss_valid = 0; iss_slot = 0; iss_iter = 0;
    wr_valid = 0; wr_slot = 0; wr_iter = 0;
  endtask

  task automatic cyc(input string tag);
    logic [VW-1:0] e, a;
    #4;
    e = model_out(); a = dut_out();
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  task automatic disp(input int s, input bit lie, input bit lix, input int q, input int p);
    disp_valid = 1; disp_slot = SL_W'(s); disp_lie = lie; disp_lix = lix;
    disp_qid = QID_W'(q); disp_preg = PR_W'(p);
  endtask
  task automatic iss(input int s, input int it);
    iss_valid = 1; iss_slot = SL_W'(s); iss_iter = ITER_W'(it);
  endtask
  task automatic wr(input int s, input int it);
    wr_valid = 1; wr_slot = SL_W'(s); wr_iter = ITER_W'(it);
  endtask

  initial begin
    int n = 0;
    while (n < 5000) begin @(posedge clk); n++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    iss(0, 0); wr(0, 0); cyc("R1");
    // strictly live-in slot 0
    disp(0, 1, 0, 5, 3); cyc("R6");
    iss(0, 0); cyc("R2");
    iss(0, 1); wr(0, 1); cyc("R4");
    iss(0, 9); wr(0, 2); cyc("R4");
    // recurrence slot 1: queue 2, global 7
    disp(1, 1, 1, 2, 7); cyc("R6");
    iss(1, 0); cyc("R3");
    iss(1, 1); cyc("R3");
    wr(1, 3); cyc("R11");
    wr(1, 11); cyc("R9");
    iss(1, 3); wr(1, 11); cyc("R9");
    wr(1, 11); cyc("R9");
    wr(1, 12); cyc("R8");
    // final iteration reported, then only iteration 12 commits
    vl_valid = 1; vl_slot = 1; vl_last = 12; cyc("R8");
    wr(1, 5); cyc("R8");
    iss(1, 12); cyc("R5");
    wr(1, 12); cyc("R7");
    cyc("R7");
    // local slot 2 reading queue 4 with wrap
    disp(2, 0, 0, 4, 0); cyc("R5");
    iss(2, 9); cyc("R5");
    iss(2, 15); wr(2, 15); cyc("R5");
    // new dispatch onto queue 2 frees its elements
    wr(1, 20); cyc("R9");
    disp(3, 0, 1, 2, 9); cyc("R10");
    wr(3, 20); cyc("R10");
    wr(3, 0); cyc("R8");
    vl_valid = 1; vl_slot = 3; vl_last = 1; cyc("R8");
    wr(3, 1); cyc("R7");
    iss(3, 1); wr(3, 2); cyc("R11");
    cyc("R7");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule